// File: doc/BRIEF.md
# Up-Counting Time Base with Buffered Reload

This block is a programmable time base. A prescaler divides the input clock by a chosen ratio. An up-counter advances on each prescaler tick, runs from zero up to an active reload value, then returns to zero. The wrap, or a software request, raises an update event. The update event copies the buffered prescaler ratio, and the buffered reload value when buffering is selected, into their active registers. It also sets a status flag and can drive an interrupt line, a DMA request pulse and a selectable trigger line.

Software reaches every setting through a flat register bus with a write strobe, a 3-bit word address, write data and combinational read data. An update-suppress bit blocks update events. A flag-source bit keeps software updates from raising the flag. A single-shot bit stops the counter at its first update. A freeze input holds the count while a debugger has the system halted.

Top module: `basic_timer`

## Requirements
- R1: After reset, every word reads 0 except word 7 (reload), which reads 0xFFFF, and all outputs are low. Word map: 0 control, 1 trigger select, 2 enables, 3 status, 4 event, 5 count, 6 prescale, 7 reload. Control bits: bit0 run, bit1 update suppress, bit2 flag source, bit3 single shot, bit4 reload buffering.
- R2: With a prescale of P and an active reload of A > 0, the count steps from 0 to A and then back to 0. On that wrap, update_o is high for one cycle, in the cycle where the count reads 0.
- R3: The count advances once per P+1 clocks while running. The internal run state follows the control run bit one clock later.
- R4: A write to word 6 changes the read-back value at once. The division ratio changes only at the next update event.
- R5: With reload buffering at 0, a write to word 7 becomes the active limit at once. With it at 1, the value waits until the next update event.
- R6: Writing 1 to bit0 of word 4 clears the count and the prescaler counter one cycle later and raises an update event. Word 4 always reads 0.
- R7: While update suppress is 1, neither a wrap nor an event write produces an update: update_o stays low, the flag is not set and the active registers are kept. An event write still clears the counters.
- R8: With flag source at 1, an update from an event write reloads the registers but sets no flag and raises no interrupt or DMA request. A wrap still sets the flag.
- R9: With single shot at 1, the run bit clears itself at the same edge as an update event, so counting stops.
- R10: While the active reload is 0, the count and the prescaler counter hold.
- R11: Word 1 bits [2:0] select trig_o: 0 gives the delayed event-write pulse, 1 gives the internal run state, 2 gives update_o, and any other value gives 0.
- R12: Status bit0 is set by each flag-raising update. Writing 0 clears it, and writing 1 leaves it unchanged. irq_o is the flag gated by enable bit0. dma_req_o is a one-cycle pulse on each flag-raising update when enable bit1 is 1.
- R13: While freeze_i is 1, the count and the prescaler counter hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| freeze_i | input | 1 | Holds counting while high |
| update_o | output | 1 | One-cycle update event pulse |
| irq_o | output | 1 | Interrupt request level |
| dma_req_o | output | 1 | One-cycle DMA request pulse |
| trig_o | output | 1 | Selected trigger output |

## Verification
A write lands at the next rising edge, so its read-back is due in the following cycle. An event write acts one edge after that. A run-bit write starts counting one further edge later. update_o, dma_req_o and the flag show a wrap in the cycle that follows the edge where the count returns to 0. The bench steps a reference model on each rising edge from the same inputs. It samples the outputs and rdata_o at the falling edge and changes inputs only after it, so every comparison falls in the cycle where each of these latencies says the result appears.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0, A_TRIG = 3'd1, A_IEN = 3'd2, A_STAT = 3'd3,
    A_EVT  = 3'd4, A_CNT  = 3'd5, A_PSC = 3'd6, A_RLD  = 3'd7
  } addr_e;

  typedef enum logic [2:0] {
    TRG_GEN = 3'd0, TRG_RUN = 3'd1, TRG_UPD = 3'd2
  } trig_e;

  typedef struct packed {
    logic reload_buf;
    logic single;
    logic flag_src;
    logic upd_off;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  logic [W-1:0] div_q;

  assign tick_o = run_i && (div_q >= ratio_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (run_i)  div_q <= tick_o ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  // clear and write take priority over a step, so they swallow the wrap
  assign wrap_o = step_i && !clr_i && !wr_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wr_i)    cnt_q <= wdata_i;
    else if (step_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic              wrap_i,
  input  logic [W-1:0]      cnt_i,
  output ctrl_t             ctrl_o,
  output logic [W-1:0]      psc_act_o,
  output logic [W-1:0]      arr_act_o,
  output logic              ug_o,
  output logic              run_o,
  output logic              cnt_wr_o,
  output logic              flag_o,
  output logic              upd_o,
  output logic              dma_o,
  output logic              irq_o,
  output logic              trig_o
);
  ctrl_t        ctrl_q, ctrl_d;
  logic [2:0]   trig_sel_q;
  logic [1:0]   ien_q;
  logic         flag_q, ug_q, run_q, upd_q, dma_q;
  logic [W-1:0] psc_pre_q, psc_act_q, arr_pre_q, arr_act_q;
  logic         uev, flag_set;

  function automatic logic hit(input addr_e a);
    return wr_en_i && (addr_i == a);
  endfunction

  assign uev      = !ctrl_q.upd_off && (wrap_i || ug_q);
  assign flag_set = uev && (wrap_i || !ctrl_q.flag_src);

  always_comb begin
    ctrl_d = ctrl_q;
    if (hit(A_CTRL)) ctrl_d = ctrl_t'(wdata_i[CTRL_W-1:0]);
    if (uev && ctrl_q.single) ctrl_d.run = 1'b0;  // hardware stop beats software
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      trig_sel_q <= '0;
      ien_q      <= '0;
      flag_q     <= 1'b0;
      ug_q       <= 1'b0;
      run_q      <= 1'b0;
      upd_q      <= 1'b0;
      dma_q      <= 1'b0;
      psc_pre_q  <= '0;
      psc_act_q  <= '0;
      arr_pre_q  <= '1;
      arr_act_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      if (hit(A_TRIG)) trig_sel_q <= wdata_i[2:0];
      if (hit(A_IEN))  ien_q      <= wdata_i[1:0];
      if (flag_set)                        flag_q <= 1'b1;
      else if (hit(A_STAT) && !wdata_i[0]) flag_q <= 1'b0;
      ug_q  <= hit(A_EVT) && wdata_i[0];
      run_q <= ctrl_q.run;
      upd_q <= uev;
      dma_q <= flag_set && ien_q[1];
      if (hit(A_PSC)) psc_pre_q <= wdata_i;
      if (uev)        psc_act_q <= psc_pre_q;
      if (hit(A_RLD)) arr_pre_q <= wdata_i;
      if (hit(A_RLD) && !ctrl_q.reload_buf) arr_act_q <= wdata_i;
      else if (uev)                         arr_act_q <= arr_pre_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_e'(addr_i))
      A_CTRL: rdata_o = W'(ctrl_q);
      A_TRIG: rdata_o = W'(trig_sel_q);
      A_IEN:  rdata_o = W'(ien_q);
      A_STAT: rdata_o = W'(flag_q);
      A_EVT:  rdata_o = '0;
      A_CNT:  rdata_o = cnt_i;
      A_PSC:  rdata_o = psc_pre_q;
      A_RLD:  rdata_o = arr_pre_q;
      default: rdata_o = '0;
    endcase
  end

  always_comb begin
    unique case (trig_sel_q)
      TRG_GEN: trig_o = ug_q;
      TRG_RUN: trig_o = run_q;
      TRG_UPD: trig_o = upd_q;
      default: trig_o = 1'b0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign psc_act_o = psc_act_q;
  assign arr_act_o = arr_act_q;
  assign ug_o      = ug_q;
  assign run_o     = run_q;
  assign cnt_wr_o  = hit(A_CNT);
  assign flag_o    = flag_q;
  assign upd_o     = upd_q;
  assign dma_o     = dma_q;
  assign irq_o     = flag_q && ien_q[0];
endmodule

// File: rtl/basic_timer.sv
module basic_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic              freeze_i,
  output logic              update_o,
  output logic              irq_o,
  output logic              dma_req_o,
  output logic              trig_o
);
  ctrl_t        ctrl_w;
  logic [W-1:0] psc_act, arr_act, cnt;
  logic         ug, run_q, cnt_wr, flag, wrap, tick, advance;

  assign advance = run_q && !freeze_i && (arr_act != '0);

  tmr_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .wrap_i(wrap), .cnt_i(cnt), .ctrl_o(ctrl_w),
    .psc_act_o(psc_act), .arr_act_o(arr_act), .ug_o(ug), .run_o(run_q),
    .cnt_wr_o(cnt_wr), .flag_o(flag), .upd_o(update_o), .dma_o(dma_req_o),
    .irq_o, .trig_o
  );

  tmr_prescaler #(.W(W)) u_psc (
    .clk_i, .rst_ni, .clr_i(ug), .run_i(advance), .ratio_i(psc_act), .tick_o(tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(ug), .wr_i(cnt_wr), .wdata_i,
    .step_i(tick), .limit_i(arr_act), .cnt_o(cnt), .wrap_o(wrap)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         update_i,
  input logic         dma_i,
  input logic         ug_i,
  input logic [W-1:0] cnt_i,
  input logic         upd_off_i,
  input logic         single_i,
  input logic         run_bit_i,
  input logic         flag_i,
  input logic [W-1:0] arr_act_i,
  input logic         cnt_wr_i,
  input logic         freeze_i
);
  a_r2_update_shows_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |-> cnt_i == '0);

  a_r6_gen_clears_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> cnt_i == '0);

  a_r7_no_update_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_off_i |=> !update_i);

  a_r9_single_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_i |=> (update_i |-> !run_bit_i));

  a_r10_zero_reload_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_act_i == '0 && !ug_i && !cnt_wr_i) |=> $stable(cnt_i));

  a_r12_dma_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_i |-> flag_i);

  a_r13_freeze_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !ug_i && !cnt_wr_i) |=> $stable(cnt_i));
endmodule

bind basic_timer tmr_checker #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .update_i(update_o), .dma_i(dma_req_o),
  .ug_i(ug), .cnt_i(cnt), .upd_off_i(ctrl_w.upd_off), .single_i(ctrl_w.single),
  .run_bit_i(ctrl_w.run), .flag_i(flag), .arr_act_i(arr_act),
  .cnt_wr_i(cnt_wr), .freeze_i(freeze_i)
);

// File: tb/tb_basic_timer.sv
module tb_basic_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic         frz = 1'b0;
  logic [W-1:0] rdata;
  logic         upd, irq, dma, trig;

  int n_chk = 0, n_fail = 0;
  bit chk_en = 1'b0, done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  basic_timer #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .freeze_i(frz), .update_o(upd), .irq_o(irq),
    .dma_req_o(dma), .trig_o(trig)
  );

  // reference model state
  logic [4:0]   m_ctrl;
  logic [2:0]   m_tsel;
  logic [1:0]   m_ien;
  logic         m_flag, m_ug, m_run, m_upd, m_dma;
  logic [W-1:0] m_psc_pre, m_psc_act, m_arr_pre, m_arr_act, m_cnt, m_div;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_tsel = '0; m_ien = '0; m_flag = 0; m_ug = 0; m_run = 0;
      m_upd = 0; m_dma = 0; m_psc_pre = '0; m_psc_act = '0;
      m_arr_pre = '1; m_arr_act = '1; m_cnt = '0; m_div = '0;
    end else begin
      logic adv, tk, wrp, uev, fset, wcnt;
      logic [4:0] c;
      wcnt = we && addr == 3'd5;
      adv  = m_run && !frz && m_arr_act != 0;
      tk   = adv && m_div == m_psc_act;
      wrp  = tk && !m_ug && !wcnt && m_cnt == m_arr_act;
      uev  = !m_ctrl[1] && (wrp || m_ug);
      fset = uev && (wrp || !m_ctrl[2]);
      c = (we && addr == 3'd0) ? wdata[4:0] : m_ctrl;
      if (uev && m_ctrl[3]) c[0] = 1'b0;
      if (m_ug) m_div = '0; else if (adv) m_div = tk ? '0 : m_div + 1'b1;
      if (m_ug) m_cnt = '0;
      else if (wcnt) m_cnt = wdata;
      else if (tk) m_cnt = wrp ? '0 : m_cnt + 1'b1;
      m_run = m_ctrl[0];
      if (uev) m_psc_act = m_psc_pre;
      if (we && addr == 3'd7 && !m_ctrl[4]) m_arr_act = wdata;
      else if (uev) m_arr_act = m_arr_pre;
      if (we && addr == 3'd6) m_psc_pre = wdata;
      if (we && addr == 3'd7) m_arr_pre = wdata;
      if (we && addr == 3'd1) m_tsel = wdata[2:0];
      if (we && addr == 3'd2) m_ien = wdata[1:0];
      if (fset) m_flag = 1'b1; else if (we && addr == 3'd3 && !wdata[0]) m_flag = 1'b0;
      m_ug = we && addr == 3'd4 && wdata[0];
      m_upd = uev;
      m_dma = fset && m_ien[1];
      m_ctrl = c;
    end
  end

  function automatic logic [W-1:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return W'(m_ctrl);
      3'd1: return W'(m_tsel);
      3'd2: return W'(m_ien);
      3'd3: return W'(m_flag);
      3'd5: return m_cnt;
      3'd6: return m_psc_pre;
      3'd7: return m_arr_pre;
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_trig();
    case (m_tsel)
      3'd0: return m_ug;
      3'd1: return m_run;
      3'd2: return m_upd;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_en && !done) begin
      check(W'(upd),  W'(m_upd), "R2 update_o");
      check(W'(irq),  W'(m_flag && m_ien[0]), "R12 irq_o");
      check(W'(dma),  W'(m_dma), "R12 dma_req_o");
      check(W'(trig), W'(exp_trig()), "R11 trig_o");
      check(rdata, exp_read(addr), cur_req);
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #2 we = 1'b0; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); #2 we = 1'b1; addr = a; wdata = d;
    @(negedge clk); #2 we = 1'b0;
  endtask

  task automatic hand(input logic [2:0] a, input logic [W-1:0] e, input string req);
    @(negedge clk); #2 we = 1'b0; addr = a;
    @(negedge clk); #1 check(rdata, e, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values, hand computed
    for (int a = 0; a < 8; a++) hand(3'(a), (a == 7) ? 16'hFFFF : 16'h0, "R1 reset read");
    check({13'b0, upd, irq, dma}, '0, "R1 reset outputs");
    chk_en = 1'b1;
    cur_req = "R2";  wr(3'd7, 16'd3); wr(3'd0, 16'h01); idle(20);
    cur_req = "R4";  wr(3'd6, 16'd2); idle(8);
    cur_req = "R3";  wr(3'd4, 16'd1); idle(30);
    cur_req = "R5";  wr(3'd7, 16'd5); idle(10); wr(3'd0, 16'h11); wr(3'd7, 16'd1); idle(30);
    cur_req = "R6";  wr(3'd4, 16'd1); idle(4);
    cur_req = "R7";  wr(3'd6, 16'd0); wr(3'd0, 16'h03); idle(30); wr(3'd4, 16'd1); idle(6);
    cur_req = "R8";  wr(3'd0, 16'h05); wr(3'd2, 16'd3); wr(3'd3, 16'd0);
                     wr(3'd4, 16'd1); idle(6); idle(20);
    cur_req = "R9";  wr(3'd0, 16'h00); wr(3'd7, 16'd3); wr(3'd3, 16'd0);
                     wr(3'd0, 16'h09); idle(40);
    hand(3'd0, 16'h0008, "R9 run bit cleared");
    cur_req = "R10"; wr(3'd7, 16'd0); wr(3'd5, 16'd4); wr(3'd0, 16'h01); idle(20);
    hand(3'd5, 16'd4, "R10 count held");
    cur_req = "R11";
    for (int s = 0; s < 4; s++) begin
      wr(3'd1, 16'(s)); wr(3'd7, 16'd3); wr(3'd4, 16'd1); idle(12);
    end
    cur_req = "R12"; wr(3'd0, 16'h00); wr(3'd3, 16'd0); idle(2); wr(3'd3, 16'd1);
    hand(3'd3, 16'd0, "R12 write one ignored");
    cur_req = "R13"; wr(3'd0, 16'h01); idle(5);
    @(negedge clk); #2 frz = 1'b1; idle(12); hand(3'd5, m_cnt, "R13 frozen count");
    @(negedge clk); #2 frz = 1'b0; idle(10);
    cur_req = "R2 random";
    for (int i = 0; i < 1500; i++) begin
      int unsigned op;
      logic [W-1:0] d;
      logic [2:0] a;
      op = $urandom_range(0, 9);
      a = 3'($urandom_range(0, 7));
      case (a)
        3'd0: d = {11'b0, 1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
                   1'($urandom_range(0, 1)), ($urandom_range(0, 5) == 0),
                   ($urandom_range(0, 9) != 0)};
        3'd6: d = 16'($urandom_range(0, 3));
        3'd5, 3'd7: d = 16'($urandom_range(0, 12));
        default: d = 16'($urandom_range(0, 7));
      endcase
      @(negedge clk); #2;
      frz = ($urandom_range(0, 9) == 0);
      we = (op < 3); addr = a; wdata = d;
    end
    @(negedge clk); #2 we = 1'b0; frz = 1'b0;
    idle(5);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule